// File: doc/BRIEF.md
# Read-Armed Interrupt Flag Controller

This block keeps the interrupt flags of a message-buffer controller. There is one sticky flag for each message buffer and one each for three status sources: bus-off, error and wake-up. A one-cycle pulse on a source's event input sets its flag.

Software clears a flag with a two-step handshake. It reads the register while the flag is 1, which arms the bit. It then writes 1 to that bit. Any write to the register disarms all of its bits. An event on a bit, whether it falls between the read and the write or in the write cycle itself, also disarms that bit and keeps the flag set. So an event that arrives while software is servicing the interrupt is never lost.

Per-source masks gate the flags into a single registered interrupt request. The configuration register also carries a halt request, which the protocol engine sees on `halt_o`. The matching not-ready status bit follows the halt request one cycle later. A self-clearing soft-reset bit clears every flag, arm bit and mask.

Register map (address, 16-bit data):

| Address | Register |
|---|---|
| 0 | configuration |
| 1 | control |
| 2 | buffer flags |
| 3 | buffer mask |
| 4 | status flags |

Configuration register bits:
- bit 12: halt request (read/write).
- bit 11: not-ready (read-only).
- bit 10: wake-up mask.
- bit 9: soft reset (reads back while it is active).
- bits 15:13, 8 and 7:0: plain read/write storage.

Control register bits:
- bit 15: bus-off mask.
- bit 14: error mask.
- All other bits read 0.

Status flag register bits:
- bit 0: bus-off.
- bit 1: error.
- bit 2: wake-up.

Reads are combinational: `rdata_o` reflects the register at `addr_i` in the same cycle. Unmapped addresses read 0.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A pulse on `buf_evt_i[i]` sets bit i of the buffer flag register (address 2) at the next clock edge.
- R2: A read of address 2 that returns bit i as 1 arms that bit. A following write of 1 to bit i clears the flag at that write's clock edge.
- R3: A write of 0 to a flag bit leaves it unchanged. A write of 1 to a bit that is not armed also leaves it unchanged.
- R4: Any write to a flag register disarms all of its bits. An event on a bit, either between the arming read and the write or in the write cycle itself, disarms that bit and keeps the flag set.
- R5: The status flag register (address 4; bus-off bit 0, error bit 1, wake-up bit 2) is set by `busoff_evt_i`, `err_evt_i` and `wake_evt_i`. It follows the same arm and clear rules, independently of the buffer flags.
- R6: `irq_o` is 1 one clock after any flag is 1 together with its mask, and 0 one clock after no such pair exists. The masks are:
  - buffer mask register, address 3, bit i for buffer i;
  - control bit 15 for bus-off;
  - control bit 14 for error;
  - configuration bit 10 for wake-up.
- R7: Writing configuration bit 12 (halt) drives `halt_o` from the next edge. Configuration bit 11 (not-ready) equals the halt bit one cycle later, so it sets after halt is set and clears one cycle after halt is cleared.
- R8: After reset:
  - the configuration register reads 0x5980 (halt = 1, not-ready = 1);
  - all other registers read 0;
  - `irq_o` = 0 and `halt_o` = 1.
- R9: Writing 1 to configuration bit 9 sets the soft-reset bit, which reads 1 for one cycle. At the next edge it clears all flags, arm bits and masks, then clears itself. Halt, not-ready and the plain storage bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| buf_evt_i | input | 16 | Per-buffer completion pulses |
| busoff_evt_i | input | 1 | Bus-off event pulse |
| err_evt_i | input | 1 | Error event pulse |
| wake_evt_i | input | 1 | Wake-up event pulse |
| halt_o | output | 1 | Halt request to the protocol engine |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
A wrong arm bit shows up at the very next write to a flag register. A stuck arm makes the flag clear without a fresh read, and a dropped arm keeps it set. Either is visible on the read-back one cycle later. A lost event during the read-write window shows as a flag reading 0 right after the clearing write. The checks therefore read back immediately after every handshake step. A stale mask or flag shows on `irq_o` exactly two edges after the event pulse, and a not-ready bit off by one cycle shows on the read that directly follows a halt write.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int NUM_ST = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG   = 3'd0,
    A_CTRL  = 3'd1,
    A_BFLAG = 3'd2,
    A_BMASK = 3'd3,
    A_STAT  = 3'd4
  } reg_addr_e;

  localparam int CFG_HALT = 12;
  localparam int CFG_NRDY = 11;
  localparam int CFG_WMSK = 10;
  localparam int CFG_SRST = 9;
  localparam logic [DATA_W-1:0] CFG_RST  = 16'h5980;
  localparam logic [DATA_W-1:0] CFG_KEEP = 16'hE1FF;

  localparam int CTRL_BOMSK = 15;
  localparam int CTRL_ERMSK = 14;

  localparam int ST_BO = 0;
  localparam int ST_ER = 1;
  localparam int ST_WK = 2;
endpackage

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] evt_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] arm_o
);
  logic [W-1:0] flag_q, arm_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit = wr_i & wdata_i[i] & arm_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else if (clr_i) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        // event wins over a clearing write in the same cycle
        flag_q[i] <= evt_i[i] | (flag_q[i] & ~clr_hit);
        if (evt_i[i] || wr_i)          arm_q[i] <= 1'b0;
        else if (rd_i && flag_q[i])    arm_q[i] <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import ifc_pkg::*;
#(
  parameter int NUM_BUF = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_cfg_i,
  input  logic               wr_ctrl_i,
  input  logic               wr_bmask_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  cfg_rd_o,
  output logic [DATA_W-1:0]  ctrl_rd_o,
  output logic [NUM_BUF-1:0] bmask_o,
  output logic [NUM_ST-1:0]  st_mask_o,
  output logic               halt_o,
  output logic               nrdy_o,
  output logic               srst_o
);
  logic [DATA_W-1:0]  keep_q;
  logic [NUM_BUF-1:0] bmask_q;
  logic               halt_q, nrdy_q, srst_q;
  logic               bo_msk_q, er_msk_q, wk_msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= CFG_RST & CFG_KEEP;
      halt_q <= CFG_RST[CFG_HALT];
      nrdy_q <= CFG_RST[CFG_NRDY];
      srst_q <= 1'b0;
    end else begin
      nrdy_q <= halt_q;
      if (srst_q) srst_q <= 1'b0;
      else if (wr_cfg_i && wdata_i[CFG_SRST]) srst_q <= 1'b1;
      if (wr_cfg_i) begin
        keep_q <= wdata_i & CFG_KEEP;
        halt_q <= wdata_i[CFG_HALT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bmask_q  <= '0;
      bo_msk_q <= 1'b0;
      er_msk_q <= 1'b0;
      wk_msk_q <= 1'b0;
    end else if (srst_q) begin
      bmask_q  <= '0;
      bo_msk_q <= 1'b0;
      er_msk_q <= 1'b0;
      wk_msk_q <= 1'b0;
    end else begin
      if (wr_bmask_i) bmask_q <= wdata_i[NUM_BUF-1:0];
      if (wr_ctrl_i) begin
        bo_msk_q <= wdata_i[CTRL_BOMSK];
        er_msk_q <= wdata_i[CTRL_ERMSK];
      end
      if (wr_cfg_i) wk_msk_q <= wdata_i[CFG_WMSK];
    end
  end

  always_comb begin
    cfg_rd_o           = keep_q;
    cfg_rd_o[CFG_HALT] = halt_q;
    cfg_rd_o[CFG_NRDY] = nrdy_q;
    cfg_rd_o[CFG_WMSK] = wk_msk_q;
    cfg_rd_o[CFG_SRST] = srst_q;
    ctrl_rd_o             = '0;
    ctrl_rd_o[CTRL_BOMSK] = bo_msk_q;
    ctrl_rd_o[CTRL_ERMSK] = er_msk_q;
    st_mask_o          = '0;
    st_mask_o[ST_BO]   = bo_msk_q;
    st_mask_o[ST_ER]   = er_msk_q;
    st_mask_o[ST_WK]   = wk_msk_q;
  end

  assign bmask_o = bmask_q;
  assign halt_o  = halt_q;
  assign nrdy_o  = nrdy_q;
  assign srst_o  = srst_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NB = 16,
  parameter int NS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] bflag_i,
  input  logic [NB-1:0] bmask_i,
  input  logic [NS-1:0] sflag_i,
  input  logic [NS-1:0] smask_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(bflag_i & bmask_i)) | (|(sflag_i & smask_i));
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import ifc_pkg::*;
#(
  parameter int NUM_BUF = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_BUF-1:0] buf_evt_i,
  input  logic               busoff_evt_i,
  input  logic               err_evt_i,
  input  logic               wake_evt_i,
  output logic               halt_o,
  output logic               irq_o
);
  logic               rd_en, wr_en;
  logic [DATA_W-1:0]  cfg_rd, ctrl_rd;
  logic [NUM_BUF-1:0] buf_flag, buf_arm, buf_mask;
  logic [NUM_ST-1:0]  st_flag, st_arm, st_mask, st_evt;
  logic               nrdy, srst;

  assign rd_en  = req_i & ~we_i;
  assign wr_en  = req_i &  we_i;
  assign st_evt = {wake_evt_i, err_evt_i, busoff_evt_i};

  flag_bank #(.W(NUM_BUF)) u_buf_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst),
    .evt_i   (buf_evt_i),
    .rd_i    (rd_en && addr_i == A_BFLAG),
    .wr_i    (wr_en && addr_i == A_BFLAG),
    .wdata_i (wdata_i[NUM_BUF-1:0]),
    .flag_o  (buf_flag),
    .arm_o   (buf_arm)
  );

  flag_bank #(.W(NUM_ST)) u_st_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst),
    .evt_i   (st_evt),
    .rd_i    (rd_en && addr_i == A_STAT),
    .wr_i    (wr_en && addr_i == A_STAT),
    .wdata_i (wdata_i[NUM_ST-1:0]),
    .flag_o  (st_flag),
    .arm_o   (st_arm)
  );

  cfg_regs #(.NUM_BUF(NUM_BUF)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cfg_i   (wr_en && addr_i == A_CFG),
    .wr_ctrl_i  (wr_en && addr_i == A_CTRL),
    .wr_bmask_i (wr_en && addr_i == A_BMASK),
    .wdata_i    (wdata_i),
    .cfg_rd_o   (cfg_rd),
    .ctrl_rd_o  (ctrl_rd),
    .bmask_o    (buf_mask),
    .st_mask_o  (st_mask),
    .halt_o     (halt_o),
    .nrdy_o     (nrdy),
    .srst_o     (srst)
  );

  irq_merge #(.NB(NUM_BUF), .NS(NUM_ST)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bflag_i (buf_flag),
    .bmask_i (buf_mask),
    .sflag_i (st_flag),
    .smask_i (st_mask),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CFG:   rdata_o = cfg_rd;
      A_CTRL:  rdata_o = ctrl_rd;
      A_BFLAG: rdata_o[NUM_BUF-1:0] = buf_flag;
      A_BMASK: rdata_o[NUM_BUF-1:0] = buf_mask;
      A_STAT:  rdata_o[NUM_ST-1:0]  = st_flag;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NUM_BUF = 16,
  parameter int NUM_ST  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_BUF-1:0] buf_evt_i,
  input logic [NUM_BUF-1:0] buf_flag,
  input logic [NUM_BUF-1:0] buf_arm,
  input logic [NUM_BUF-1:0] buf_mask,
  input logic [NUM_ST-1:0]  st_evt,
  input logic [NUM_ST-1:0]  st_flag,
  input logic [NUM_ST-1:0]  st_arm,
  input logic [NUM_ST-1:0]  st_mask,
  input logic               halt_o,
  input logic               nrdy,
  input logic               srst,
  input logic               irq_o
);
  // R1
  p_evt_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst |=> ((buf_flag & $past(buf_evt_i)) == $past(buf_evt_i)));

  // R2: a flag may only fall if it was armed
  p_clear_needs_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst |=> (($past(buf_flag) & ~buf_flag & ~$past(buf_arm)) == '0));

  // R4
  p_evt_disarms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|buf_evt_i) |=> ((buf_arm & $past(buf_evt_i)) == '0));

  // R5
  p_st_clear_needs_arm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst |=> (($past(st_flag) & ~st_flag & ~$past(st_arm)) == '0));

  p_st_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst |=> ((st_flag & $past(st_evt)) == $past(st_evt)));

  // R6
  p_irq_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((buf_flag & buf_mask) == '0) && ((st_flag & st_mask) == '0)) |=> !irq_o);

  // R7
  p_nrdy_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (nrdy == $past(halt_o)));

  // R9
  p_srst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (!srst && buf_flag == '0 && st_flag == '0 && buf_mask == '0
              && buf_arm == '0 && st_arm == '0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NUM_BUF(NUM_BUF), .NUM_ST(ifc_pkg::NUM_ST)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .buf_evt_i (buf_evt_i),
  .buf_flag  (buf_flag),
  .buf_arm   (buf_arm),
  .buf_mask  (buf_mask),
  .st_evt    (st_evt),
  .st_flag   (st_flag),
  .st_arm    (st_arm),
  .st_mask   (st_mask),
  .halt_o    (halt_o),
  .nrdy      (nrdy),
  .srst      (srst),
  .irq_o     (irq_o)
);

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/100ps
module irq_flag_ctrl_bench;
  localparam logic [2:0] A_CFG = 3'd0, A_CTRL = 3'd1, A_BFLAG = 3'd2,
                         A_BMASK = 3'd3, A_STAT = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [15:0] buf_evt = '0;
  logic        bo_evt = 1'b0, er_evt = 1'b0, wk_evt = 1'b0;
  logic        halt, irq;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .buf_evt_i(buf_evt),
    .busoff_evt_i(bo_evt), .err_evt_i(er_evt), .wake_evt_i(wk_evt),
    .halt_o(halt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    req = 1'b1; we = 1'b0; addr = a;
    #1 chk(tag, rdata, exp);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse_buf(input logic [15:0] v);
    buf_evt = v;
    @(negedge clk);
    buf_evt = '0;
  endtask

  task automatic pulse_st(input logic [2:0] v);
    {wk_evt, er_evt, bo_evt} = v;
    @(negedge clk);
    {wk_evt, er_evt, bo_evt} = 3'b000;
  endtask

  task automatic t_reset;
    chk("R8 irq", {15'b0, irq}, 16'h0);
    chk("R8 halt_o", {15'b0, halt}, 16'h1);
    rd_chk("R8 cfg", A_CFG, 16'h5980);
    rd_chk("R8 ctrl", A_CTRL, 16'h0);
    rd_chk("R8 bflag", A_BFLAG, 16'h0);
    rd_chk("R8 bmask", A_BMASK, 16'h0);
    rd_chk("R8 stat", A_STAT, 16'h0);
  endtask

  task automatic t_buf_set;
    pulse_buf(16'h8001);
    rd_chk("R1 set", A_BFLAG, 16'h8001);
  endtask

  task automatic t_unarmed;
    wr(A_BFLAG, 16'h0000);
    rd_chk("R3 write zero", A_BFLAG, 16'h8001);
    wr(A_BFLAG, 16'h0000);
    wr(A_BFLAG, 16'hFFFF);
    rd_chk("R3 unarmed one", A_BFLAG, 16'h8001);
  endtask

  task automatic t_armed_clear;
    wr(A_BFLAG, 16'h0001);
    rd_chk("R2 armed clear", A_BFLAG, 16'h8000);
    wr(A_BFLAG, 16'h0000);
    wr(A_BFLAG, 16'h8000);
    rd_chk("R4 write disarms", A_BFLAG, 16'h8000);
    wr(A_BFLAG, 16'h8000);
    rd_chk("R2 second clear", A_BFLAG, 16'h0000);
  endtask

  task automatic t_evt_race;
    pulse_buf(16'h0008);
    rd_chk("R1 bit3", A_BFLAG, 16'h0008);
    pulse_buf(16'h0008);
    wr(A_BFLAG, 16'h0008);
    rd_chk("R4 event between", A_BFLAG, 16'h0008);
    buf_evt = 16'h0008;
    req = 1'b1; we = 1'b1; addr = A_BFLAG; wdata = 16'h0008;
    @(negedge clk);
    req = 1'b0; we = 1'b0; buf_evt = '0;
    rd_chk("R4 event in write", A_BFLAG, 16'h0008);
    wr(A_BFLAG, 16'h0008);
    rd_chk("R2 clear after race", A_BFLAG, 16'h0000);
  endtask

  task automatic t_status;
    pulse_st(3'b111);
    rd_chk("R5 set", A_STAT, 16'h0007);
    wr(A_STAT, 16'h0000);
    wr(A_STAT, 16'h0007);
    rd_chk("R5 unarmed", A_STAT, 16'h0007);
    wr(A_STAT, 16'h0002);
    rd_chk("R5 clear error", A_STAT, 16'h0005);
    wr(A_STAT, 16'h0005);
    rd_chk("R5 clear rest", A_STAT, 16'h0000);
    rd_chk("R5 bflag untouched", A_BFLAG, 16'h0000);
  endtask

  task automatic t_irq;
    wr(A_BMASK, 16'h0010);
    pulse_buf(16'h0010);
    chk("R6 irq one edge", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R6 irq two edges", {15'b0, irq}, 16'h1);
    rd_chk("R6 flag", A_BFLAG, 16'h0010);
    wr(A_BFLAG, 16'h0010);
    chk("R6 irq held", {15'b0, irq}, 16'h1);
    @(negedge clk);
    chk("R6 irq drop", {15'b0, irq}, 16'h0);
    pulse_buf(16'h0001);
    @(negedge clk);
    chk("R6 unmasked", {15'b0, irq}, 16'h0);
    wr(A_CTRL, 16'h8000);
    rd_chk("R6 ctrl", A_CTRL, 16'h8000);
    pulse_st(3'b001);
    @(negedge clk);
    chk("R6 busoff irq", {15'b0, irq}, 16'h1);
    rd_chk("R6 stat", A_STAT, 16'h0001);
    wr(A_STAT, 16'h0001);
    @(negedge clk);
    chk("R6 busoff drop", {15'b0, irq}, 16'h0);
    pulse_st(3'b010);
    @(negedge clk);
    chk("R6 error unmasked", {15'b0, irq}, 16'h0);
    wr(A_CTRL, 16'h4000);
    @(negedge clk);
    chk("R6 error masked in", {15'b0, irq}, 16'h1);
    wr(A_CTRL, 16'h0000);
    wr(A_CFG, 16'h5D80);
    pulse_st(3'b100);
    @(negedge clk);
    chk("R6 wake irq", {15'b0, irq}, 16'h1);
    rd_chk("R6 stat wake", A_STAT, 16'h0006);
    wr(A_STAT, 16'h0006);
    wr(A_CFG, 16'h5980);
    rd_chk("R6 stat clear", A_STAT, 16'h0000);
  endtask

  task automatic t_halt;
    wr(A_CFG, 16'h4180);
    chk("R7 halt_o low", {15'b0, halt}, 16'h0);
    rd_chk("R7 nrdy lags", A_CFG, 16'h4980);
    rd_chk("R7 nrdy clear", A_CFG, 16'h4180);
    wr(A_CFG, 16'h5180);
    chk("R7 halt_o high", {15'b0, halt}, 16'h1);
    rd_chk("R7 nrdy lags set", A_CFG, 16'h5180);
    rd_chk("R7 nrdy set", A_CFG, 16'h5980);
  endtask

  task automatic t_srst;
    wr(A_BMASK, 16'hFFFF);
    wr(A_CTRL, 16'hC000);
    pulse_buf(16'h00F0);
    pulse_st(3'b011);
    wr(A_CFG, 16'h5F80);
    rd_chk("R9 srst visible", A_CFG, 16'h5F80);
    rd_chk("R9 self clear", A_CFG, 16'h5980);
    rd_chk("R9 bflag", A_BFLAG, 16'h0000);
    rd_chk("R9 bmask", A_BMASK, 16'h0000);
    rd_chk("R9 ctrl", A_CTRL, 16'h0000);
    rd_chk("R9 stat", A_STAT, 16'h0000);
    @(negedge clk);
    chk("R9 irq", {15'b0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buf_set();
    t_unarmed();
    t_armed_clear();
    t_evt_race();
    t_status();
    t_irq();
    t_halt();
    t_srst();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule